// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block conditions four asynchronous external interrupt pins into clean, clock-domain request lines. Each pin is first brought into the clock domain through a short flop chain. It is then interpreted under one of four sense modes: active-high level, active-low level, rising edge or falling edge.

In the level modes the request tracks the synchronised pin. In the edge modes a detected transition sets a sticky latch, which holds until software writes a one to that pin's acknowledge bit. All configuration lives in one packed 32-bit control word, which also carries a per-pin enable, a master enable that gates every pin, and a routing select for the critical group.

Pin 0 drives the request for source 0 of the critical group. Pins 1 to 3 drive main-group sources 1 to 3. A downstream group encoder consumes these requests and is not part of this block.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control word reads back as zero (every pin in sense code 0, all pins disabled, master off, routing select low), and every request output is low.
- R2: A write stores the sense code of pin n at bits [23-2n:22-2n], the enable of pin n at bit 11-n, the master enable at bit 12 and the routing select at bit 0. Reading returns exactly these fields; all other bits, including the acknowledge bits 27..24, read as zero.
- R3: Sense code 0 asserts the request while the synchronised pin is high. Sense code 3 asserts it while the synchronised pin is low.
- R4: Sense code 1 latches a request on a low-to-high transition of the synchronised pin. The request stays asserted after the pin returns low.
- R5: Sense code 2 latches a request on a high-to-low transition of the synchronised pin. The request stays asserted while the pin stays low or rises again.
- R6: Writing a one to bit 27-n clears the latched edge request of pin n. A pin whose acknowledge bit is written as zero keeps its latch.
- R7: A pin whose enable bit (11-n) is zero never asserts its request output, whatever the pin does.
- R8: With the master enable (bit 12) at zero, no request output asserts.
- R9: Pin 0 drives `crit_req_o`. Pin n (n = 1..3) drives `main_req_o[n-1]`, which is main-group source n.
- R10: A level request appears two clock edges after the pin changes. An edge request appears three clock edges after the transition.
- R11: An edge is latched even while the pin or the master enable is off, so the request shows as soon as both enables are set. Switching a pin to a level mode discards its latch.
- R12: `crit_route_o` follows the stored routing select bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data, including acknowledge bits |
| cfg_rdata | output | 32 | Stored control word |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| crit_req_o | output | 1 | Critical-group source 0 request (pin 0) |
| main_req_o | output | 3 | Main-group source 1..3 requests (pins 1..3) |
| crit_route_o | output | 1 | Critical interrupt routing select |

## Verification
Every pin is swept through all four sense codes with the same pin pattern: idle low, raise, lower, then acknowledge. The expected request at each step is computed from the code, which separates the level modes from the sticky edge modes and rising from falling. The acknowledge step tells edge latches, which clear, apart from level-low, which stays asserted because the pin is still low. Single-cycle pin steps measure the two- and three-edge latencies. Runs with the pin enable and the master enable off show both the gating and the capture of edges while masked.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int PIN_COUNT  = 4;
    localparam int REG_W      = 32;
    localparam int MASTER_BIT = 12;
    localparam int ROUTE_BIT  = 0;

    typedef enum logic [1:0] {
        SENSE_LVL_HI = 2'd0,
        SENSE_RISE   = 2'd1,
        SENSE_FALL   = 2'd2,
        SENSE_LVL_LO = 2'd3
    } sense_e;

    function automatic int sense_lsb(input int n);
        return 22 - 2 * n;
    endfunction

    function automatic int enable_bit(input int n);
        return 11 - n;
    endfunction

    function automatic int ack_bit(input int n);
        return 27 - n;
    endfunction

    typedef struct packed {
        logic [PIN_COUNT-1:0][1:0] sense;
        logic [PIN_COUNT-1:0]      pin_en;
        logic                      master_en;
        logic                      route_sel;
    } ctrl_t;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [1:0] sense_i,
    input  logic       clr_i,
    output logic       raw_o
);
    typedef struct packed {
        logic prev;
        logic latch;
    } det_t;

    det_t det_d, det_q;
    logic edge_mode;
    logic edge_seen;

    always_comb begin
        edge_mode = (sense_i == SENSE_RISE) || (sense_i == SENSE_FALL);
        edge_seen = (sense_i == SENSE_RISE) ? (sync_i & ~det_q.prev)
                                            : (~sync_i & det_q.prev);
        det_d.prev = sync_i;
        if (!edge_mode) det_d.latch = 1'b0;
        else            det_d.latch = (det_q.latch & ~clr_i) | edge_seen;

        case (sense_i)
            SENSE_LVL_HI: raw_o = sync_i;
            SENSE_LVL_LO: raw_o = ~sync_i;
            default:      raw_o = det_q.latch;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic [PIN_COUNT-1:0] pin_i,
    output logic                 crit_req_o,
    output logic [PIN_COUNT-2:0] main_req_o,
    output logic                 crit_route_o
);
    ctrl_t ctrl_d, ctrl_q;
    logic [PIN_COUNT-1:0] clr_pin;
    logic [PIN_COUNT-1:0] pin_sync;
    logic [PIN_COUNT-1:0] raw_req;
    logic [PIN_COUNT-1:0] gated_req;
    logic                 unused_wbits;

    assign unused_wbits = ^{cfg_wdata[31:28], cfg_wdata[15:13], cfg_wdata[7:1]};

    always_comb begin
        ctrl_d  = ctrl_q;
        clr_pin = '0;
        if (cfg_wr) begin
            for (int n = 0; n < PIN_COUNT; n++) begin
                ctrl_d.sense[n]  = cfg_wdata[sense_lsb(n) +: 2];
                ctrl_d.pin_en[n] = cfg_wdata[enable_bit(n)];
                clr_pin[n]       = cfg_wdata[ack_bit(n)];
            end
            ctrl_d.master_en = cfg_wdata[MASTER_BIT];
            ctrl_d.route_sel = cfg_wdata[ROUTE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        cfg_rdata = '0;
        for (int n = 0; n < PIN_COUNT; n++) begin
            cfg_rdata[sense_lsb(n) +: 2] = ctrl_q.sense[n];
            cfg_rdata[enable_bit(n)]     = ctrl_q.pin_en[n];
        end
        cfg_rdata[MASTER_BIT] = ctrl_q.master_en;
        cfg_rdata[ROUTE_BIT]  = ctrl_q.route_sel;
    end

    ext_irq_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_i),
        .sync_o (pin_sync)
    );

    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
        ext_irq_detect det_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (pin_sync[g]),
            .sense_i(ctrl_q.sense[g]),
            .clr_i  (clr_pin[g]),
            .raw_o  (raw_req[g])
        );
        assign gated_req[g] = raw_req[g] & ctrl_q.pin_en[g] & ctrl_q.master_en;
    end

    assign crit_req_o   = gated_req[0];
    assign main_req_o   = gated_req[PIN_COUNT-1:1];
    assign crit_route_o = ctrl_q.route_sel;
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        crit_req_o,
    input logic [2:0]  main_req_o
);
    // R2: stored fields follow the last write, acknowledge bits are not kept
    a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata == ($past(cfg_wdata) & 32'h00FF_1F01)));

    // R8: master enable low silences every request
    a_r8_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[12] |-> (!crit_req_o && main_req_o == 3'b000));

    // R7: pin 0 disabled keeps the critical request low
    a_r7_pin0_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[11] |-> !crit_req_o);

    // R7: pin 3 disabled keeps main source 3 low
    a_r7_pin3_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[8] |-> !main_req_o[2]);

    // R4: a latched rising request on pin 0 holds while no write occurs
    a_r4_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[23:22] == 2'd1 && crit_req_o && !cfg_wr) |=> crit_req_o);

    // R5: a latched falling request on pin 1 holds while no write occurs
    a_r5_fall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[21:20] == 2'd2 && main_req_o[0] && !cfg_wr) |=> main_req_o[0]);
endmodule

bind ext_irq_sense ext_irq_sense_chk chk_i (.*);

// File: tb/ext_irq_sense_tb_top.sv
`timescale 1ns/1ps
module ext_irq_sense_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  pin_i = '0;
    logic        crit_req_o;
    logic [2:0]  main_req_o;
    logic        crit_route_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ext_irq_sense dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pin_i(pin_i), .crit_req_o(crit_req_o),
        .main_req_o(main_req_o), .crit_route_o(crit_route_o)
    );

    function automatic logic [31:0] mk(input int n, input int code, input bit en,
                                       input bit master, input bit ack);
        logic [31:0] w = '0;
        w[22 - 2*n +: 2] = code[1:0];
        w[11 - n]        = en;
        w[12]            = master;
        w[27 - n]        = ack;
        return w;
    endfunction

    function automatic logic req_of(input int n);
        return (n == 0) ? crit_req_o : main_req_o[n-1];
    endfunction

    function automatic logic [3:0] all_req();
        return {main_req_o, crit_req_o};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk(cfg_rdata == 32'h0, "R1 rdata", cfg_rdata, 32'h0);
        chk(all_req() == 4'h0 && !crit_route_o, "R1 outputs",
            {all_req(), crit_route_o}, 0);

        // R2 readback mask, R12 route select
        wr(32'hFFFF_FFFF);
        chk(cfg_rdata == 32'h00FF_1F01, "R2 readback", cfg_rdata, 32'h00FF_1F01);
        chk(crit_route_o == 1'b1, "R12 route high", crit_route_o, 1);
        wr(32'h0000_0000);
        chk(crit_route_o == 1'b0, "R12 route low", crit_route_o, 0);
        wr(mk(2, 1, 1, 1, 0));
        chk(cfg_rdata == 32'h0004_1200, "R2 pin2 fields", cfg_rdata, 32'h0004_1200);

        // R3 R4 R5 R6 R9 sweep over pins and codes
        for (int n = 0; n < 4; n++) begin
            for (int code = 0; code < 4; code++) begin
                logic e;
                logic [3:0] onehot;
                onehot = 4'b0001 << n;
                pin_i = '0;
                wr(mk(n, 0, 1, 1, 0));
                cyc(4);
                wr(mk(n, code, 1, 1, 0));
                cyc(4);
                e = (code == 3);
                chk(req_of(n) == e, $sformatf("R3 idle pin%0d code%0d", n, code), req_of(n), e);
                pin_i[n] = 1'b1;
                cyc(4);
                e = (code == 0) || (code == 1);
                chk(req_of(n) == e, $sformatf("R4 high pin%0d code%0d", n, code), req_of(n), e);
                chk(all_req() == (e ? onehot : 4'h0), $sformatf("R9 map pin%0d", n),
                    all_req(), e ? onehot : 4'h0);
                pin_i[n] = 1'b0;
                cyc(4);
                e = (code == 1) || (code == 2) || (code == 3);
                chk(req_of(n) == e, $sformatf("R5 low pin%0d code%0d", n, code), req_of(n), e);
                wr(mk(n, code, 1, 1, 0));
                cyc(2);
                chk(req_of(n) == e, $sformatf("R6 zero ack keeps pin%0d code%0d", n, code), req_of(n), e);
                wr(mk(n, code, 1, 1, 1));
                cyc(2);
                e = (code == 3);
                chk(req_of(n) == e, $sformatf("R6 ack pin%0d code%0d", n, code), req_of(n), e);
            end
        end

        // R5 falling latch holds when pin rises again
        pin_i = 4'b0010;
        wr(mk(1, 2, 1, 1, 0));
        cyc(4);
        pin_i[1] = 1'b0;
        cyc(4);
        pin_i[1] = 1'b1;
        cyc(4);
        chk(main_req_o[0] == 1'b1, "R5 hold after re-rise", main_req_o[0], 1);

        // R10 latency, level high
        pin_i = '0;
        wr(mk(0, 0, 1, 1, 0));
        cyc(4);
        @(negedge clk); pin_i[0] = 1'b1;
        @(negedge clk);
        chk(crit_req_o == 1'b0, "R10 level after 1 edge", crit_req_o, 0);
        @(negedge clk);
        chk(crit_req_o == 1'b1, "R10 level after 2 edges", crit_req_o, 1);
        // R10 latency, rising edge
        pin_i = '0;
        wr(mk(0, 1, 1, 1, 1));
        cyc(4);
        @(negedge clk); pin_i[0] = 1'b1;
        cyc(2);
        chk(crit_req_o == 1'b0, "R10 edge after 2 edges", crit_req_o, 0);
        @(negedge clk);
        chk(crit_req_o == 1'b1, "R10 edge after 3 edges", crit_req_o, 1);

        // R7 pin enable gate
        pin_i = '0;
        wr(mk(3, 0, 0, 1, 0));
        pin_i[3] = 1'b1;
        cyc(4);
        chk(main_req_o[2] == 1'b0, "R7 disabled level", main_req_o[2], 0);

        // R8 master gate and R11 capture while masked
        pin_i = '0;
        wr(mk(3, 1, 1, 0, 1));
        cyc(4);
        pin_i[3] = 1'b1;
        cyc(4);
        pin_i[3] = 1'b0;
        cyc(4);
        chk(all_req() == 4'h0, "R8 master off", all_req(), 0);
        wr(mk(3, 1, 1, 1, 0));
        chk(main_req_o[2] == 1'b1, "R11 masked edge shows", main_req_o[2], 1);
        wr(mk(3, 0, 1, 1, 0));
        wr(mk(3, 1, 1, 1, 0));
        chk(main_req_o[2] == 1'b0, "R11 level mode discards latch", main_req_o[2], 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule